// File: doc/BRIEF.md
# Paged Program Address Sequencer with Interrupt Shadow

This block produces the program-memory address for a small processor core whose program space is split into pages. It holds a low program counter of `LO_W` bits and a committed page field of `PAGE_W` bits. The output address is the committed page followed by the low counter. Each cycle it receives at most one effective control event, chosen by a fixed priority. The events are a sequential step, an absolute jump or call, a relative add to the counter, a replacement of the counter's low byte, an interrupt request and a return from interrupt. The page-select field lives in the low bits of an externally held page register. That field reaches the address only when a control transfer commits it. A plain step never changes the page.

When an interrupt is accepted, execution moves to a fixed vector in page zero. In the same edge, one shadow set captures four values: the accumulator, the status register, the full page register, and the address that follows the current instruction. No further interrupt is accepted until the matching return. The return puts the saved address back into the counter. It also presents the saved register values on dedicated outputs, flagged by a one-cycle valid pulse, so that the register file can reload them.

Top module: `progseq`

## Requirements
- R1: A synchronous reset sets the program address to 0 (page 0), deasserts `in_isr` and deasserts `restore_vld`.
- R2: A step alone increments the low counter modulo 2^LO_W and leaves the page unchanged, so that the low counter wraps from all-ones to zero without a carry into the page.
- R3: A jump or a call loads the low counter from `target` and commits `pagereg_in[PAGE_W-1:0]` as the page.
- R4: An add-to-counter adds the zero-extended `operand` to the low counter modulo 2^LO_W and commits `pagereg_in[PAGE_W-1:0]` as the page.
- R5: A move-to-counter replaces the low 8 bits of the low counter with `operand`, keeps its upper bits, and commits `pagereg_in[PAGE_W-1:0]` as the page.
- R6: On a step or a cycle with no strobe, the page field of `pagereg_in` has no effect on the address.
- R7: An interrupt request accepted while `in_isr` is low sets the address to `VEC` in page 0 on the next cycle and sets `in_isr`. It takes precedence over every other strobe in that cycle.
- R8: While `in_isr` is high, `irq` is ignored and the other strobes act as if it were low.
- R9: A return while `in_isr` is high loads the address saved at entry (the entry-cycle address plus one in the low counter, with the entry-cycle page) and clears `in_isr`. It also pulses `restore_vld` for exactly one cycle, with `restore_acc`, `restore_stat` and `restore_pagereg` equal to `acc_in`, `stat_in` and `pagereg_in` as sampled at entry.
- R10: A return while `in_isr` is low is ignored, and the lower-priority strobes act as if it were low.
- R11: Among the remaining strobes, priority is jump, then call, then add-to-counter, then move-to-counter, then step.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step | input | 1 | Sequential advance |
| jump | input | 1 | Absolute jump strobe |
| call | input | 1 | Call strobe (counter and page load as for jump) |
| pc_add | input | 1 | Add operand to low counter |
| pc_mov | input | 1 | Replace low byte of low counter |
| irq | input | 1 | Interrupt request |
| reti | input | 1 | Return from interrupt |
| target | input | LO_W | Jump or call destination |
| operand | input | DW | Byte for add or move |
| acc_in | input | DW | Accumulator value to shadow |
| stat_in | input | DW | Status register value to shadow |
| pagereg_in | input | DW | Page register; low PAGE_W bits select the page |
| prog_addr | output | PAGE_W+LO_W | Program address {page, low counter} |
| in_isr | output | 1 | Shadow set occupied |
| restore_vld | output | 1 | One-cycle pulse after an accepted return |
| restore_acc | output | DW | Saved accumulator |
| restore_stat | output | DW | Saved status register |
| restore_pagereg | output | DW | Saved page register |

## Verification
Every result is registered. Whatever the strobes and data are at one rising edge shows on `prog_addr`, `in_isr`, `restore_vld` and the restore outputs one edge later, and `restore_vld` drops again on the edge after that. The bench drives inputs on the falling edge and advances its own model at the same moment. At the next falling edge, one full cycle later, it compares every output with that model. A restore output is compared only while its pulse is expected, and every comparison is credited to the requirement of the event that produced it.

// File: rtl/progseq_pkg.sv
package progseq_pkg;

  // Effective control event chosen for a cycle
  typedef enum logic [2:0] {
    OP_HOLD  = 3'd0,
    OP_STEP  = 3'd1,
    OP_JUMP  = 3'd2,
    OP_CALL  = 3'd3,
    OP_ADDPC = 3'd4,
    OP_MOVPC = 3'd5,
    OP_IRQ   = 3'd6,
    OP_RETI  = 3'd7
  } op_e;

  function automatic logic is_page_commit(input op_e op);
    return (op == OP_JUMP) || (op == OP_CALL) ||
           (op == OP_ADDPC) || (op == OP_MOVPC);
  endfunction

endpackage

// File: rtl/progseq_ctl.sv
module progseq_ctl
  import progseq_pkg::*;
(
  input  logic step,
  input  logic jump,
  input  logic call,
  input  logic pc_add,
  input  logic pc_mov,
  input  logic irq,
  input  logic reti,
  input  logic busy,
  output logic irq_take,
  output logic reti_take,
  output op_e  op
);

  assign irq_take  = irq & ~busy;
  assign reti_take = reti & busy;

  always_comb begin
    if (irq_take)       op = OP_IRQ;
    else if (reti_take) op = OP_RETI;
    else if (jump)      op = OP_JUMP;
    else if (call)      op = OP_CALL;
    else if (pc_add)    op = OP_ADDPC;
    else if (pc_mov)    op = OP_MOVPC;
    else if (step)      op = OP_STEP;
    else                op = OP_HOLD;
  end

endmodule

// File: rtl/progseq_lopc.sv
module progseq_lopc
  import progseq_pkg::*;
#(
  parameter int LO_W = 10,
  parameter int DW   = 8,
  parameter int VEC  = 8
) (
  input  logic            clk,
  input  logic            rst,
  input  op_e             op,
  input  logic [LO_W-1:0] target,
  input  logic [DW-1:0]   operand,
  input  logic [LO_W-1:0] ret_lo,
  output logic [LO_W-1:0] lo,
  output logic [LO_W-1:0] lo_seq
);

  localparam logic [LO_W-1:0] VEC_LO = LO_W'(VEC);

  function automatic logic [LO_W-1:0] f_inc(input logic [LO_W-1:0] v);
    return v + 1'b1;
  endfunction

  function automatic logic [LO_W-1:0] f_add(input logic [LO_W-1:0] v,
                                            input logic [DW-1:0]   b);
    return v + LO_W'(b);
  endfunction

  logic [LO_W-1:0] mov_val;

  generate
    if (LO_W > DW) begin : g_mov_wide
      assign mov_val = {lo[LO_W-1:DW], operand};
    end else begin : g_mov_narrow
      assign mov_val = operand[LO_W-1:0];
    end
  endgenerate

  assign lo_seq = f_inc(lo);

  always_ff @(posedge clk) begin
    if (rst) begin
      lo <= '0;
    end else begin
      case (op)
        OP_IRQ:           lo <= VEC_LO;
        OP_RETI:          lo <= ret_lo;
        OP_JUMP, OP_CALL: lo <= target;
        OP_ADDPC:         lo <= f_add(lo, operand);
        OP_MOVPC:         lo <= mov_val;
        OP_STEP:          lo <= lo_seq;
        default:          lo <= lo;
      endcase
    end
  end

endmodule

// File: rtl/progseq_page.sv
module progseq_page
  import progseq_pkg::*;
#(
  parameter int PAGE_W = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  op_e               op,
  input  logic [PAGE_W-1:0] ps_sel,
  input  logic [PAGE_W-1:0] ret_page,
  output logic [PAGE_W-1:0] page,
  output logic              commit
);

  assign commit = is_page_commit(op);

  always_ff @(posedge clk) begin
    if (rst)                page <= '0;
    else if (op == OP_IRQ)  page <= '0;
    else if (op == OP_RETI) page <= ret_page;
    else if (commit)        page <= ps_sel;
  end

endmodule

// File: rtl/progseq_shadow.sv
module progseq_shadow #(
  parameter int LO_W   = 10,
  parameter int PAGE_W = 4,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic              release_i,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     stat_in,
  input  logic [DW-1:0]     pagereg_in,
  input  logic [LO_W-1:0]   save_lo,
  input  logic [PAGE_W-1:0] save_page,
  output logic              valid,
  output logic              restore_vld,
  output logic [LO_W-1:0]   ret_lo,
  output logic [PAGE_W-1:0] ret_page,
  output logic [DW-1:0]     sh_acc,
  output logic [DW-1:0]     sh_stat,
  output logic [DW-1:0]     sh_page
);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid       <= 1'b0;
      restore_vld <= 1'b0;
      ret_lo      <= '0;
      ret_page    <= '0;
      sh_acc      <= '0;
      sh_stat     <= '0;
      sh_page     <= '0;
    end else begin
      restore_vld <= release_i;
      if (capture) begin
        valid    <= 1'b1;
        ret_lo   <= save_lo;
        ret_page <= save_page;
        sh_acc   <= acc_in;
        sh_stat  <= stat_in;
        sh_page  <= pagereg_in;
      end else if (release_i) begin
        valid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/progseq.sv
module progseq
  import progseq_pkg::*;
#(
  parameter int LO_W   = 10,
  parameter int PAGE_W = 4,
  parameter int DW     = 8,
  parameter int VEC    = 8,
  localparam int AW    = PAGE_W + LO_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step,
  input  logic              jump,
  input  logic              call,
  input  logic              pc_add,
  input  logic              pc_mov,
  input  logic              irq,
  input  logic              reti,
  input  logic [LO_W-1:0]   target,
  input  logic [DW-1:0]     operand,
  input  logic [DW-1:0]     acc_in,
  input  logic [DW-1:0]     stat_in,
  input  logic [DW-1:0]     pagereg_in,
  output logic [AW-1:0]     prog_addr,
  output logic              in_isr,
  output logic              restore_vld,
  output logic [DW-1:0]     restore_acc,
  output logic [DW-1:0]     restore_stat,
  output logic [DW-1:0]     restore_pagereg
);

  op_e               op;
  logic              irq_take;
  logic              reti_take;
  logic              page_commit;
  logic [LO_W-1:0]   lo;
  logic [LO_W-1:0]   lo_seq;
  logic [LO_W-1:0]   ret_lo;
  logic [PAGE_W-1:0] page;
  logic [PAGE_W-1:0] ret_page;
  logic [PAGE_W-1:0] ps_sel;

  assign ps_sel = pagereg_in[PAGE_W-1:0];

  progseq_ctl u_ctl (
    .step      (step),
    .jump      (jump),
    .call      (call),
    .pc_add    (pc_add),
    .pc_mov    (pc_mov),
    .irq       (irq),
    .reti      (reti),
    .busy      (in_isr),
    .irq_take  (irq_take),
    .reti_take (reti_take),
    .op        (op)
  );

  progseq_lopc #(.LO_W(LO_W), .DW(DW), .VEC(VEC)) u_lopc (
    .clk     (clk),
    .rst     (rst),
    .op      (op),
    .target  (target),
    .operand (operand),
    .ret_lo  (ret_lo),
    .lo      (lo),
    .lo_seq  (lo_seq)
  );

  progseq_page #(.PAGE_W(PAGE_W)) u_page (
    .clk      (clk),
    .rst      (rst),
    .op       (op),
    .ps_sel   (ps_sel),
    .ret_page (ret_page),
    .page     (page),
    .commit   (page_commit)
  );

  progseq_shadow #(.LO_W(LO_W), .PAGE_W(PAGE_W), .DW(DW)) u_shadow (
    .clk         (clk),
    .rst         (rst),
    .capture     (irq_take),
    .release_i   (reti_take),
    .acc_in      (acc_in),
    .stat_in     (stat_in),
    .pagereg_in  (pagereg_in),
    .save_lo     (lo_seq),
    .save_page   (page),
    .valid       (in_isr),
    .restore_vld (restore_vld),
    .ret_lo      (ret_lo),
    .ret_page    (ret_page),
    .sh_acc      (restore_acc),
    .sh_stat     (restore_stat),
    .sh_page     (restore_pagereg)
  );

  assign prog_addr = {page, lo};

endmodule

// File: rtl/progseq_chk.sv
module progseq_chk
  import progseq_pkg::*;
#(
  parameter int LO_W   = 10,
  parameter int PAGE_W = 4,
  parameter int VEC    = 8,
  localparam int AW    = PAGE_W + LO_W
) (
  input logic          clk,
  input logic          rst,
  input op_e           op,
  input logic          irq_take,
  input logic          reti_take,
  input logic          page_commit,
  input logic          irq,
  input logic [AW-1:0] prog_addr,
  input logic          in_isr,
  input logic          restore_vld
);

  // R1
  reset_state_chk: assert property (@(posedge clk)
    rst |=> (prog_addr == '0 && !in_isr && !restore_vld));

  // R2
  step_inc_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP) |=>
      prog_addr[LO_W-1:0] == LO_W'($past(prog_addr[LO_W-1:0]) + 1'b1));

  // R6
  page_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (op == OP_STEP || op == OP_HOLD) |=> $stable(prog_addr[AW-1:LO_W]));

  // R7
  irq_vector_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |=> (prog_addr == AW'(VEC) && in_isr));

  // R8
  irq_mask_chk: assert property (@(posedge clk) disable iff (rst)
    (in_isr && irq) |-> !irq_take);

  // R9
  restore_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    reti_take |=> (restore_vld && !in_isr));

  // R9
  restore_single_chk: assert property (@(posedge clk) disable iff (rst)
    restore_vld |=> !restore_vld);

  // R10
  reti_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !in_isr |-> !reti_take);

  // R7
  irq_no_commit_chk: assert property (@(posedge clk) disable iff (rst)
    irq_take |-> !page_commit);

endmodule

bind progseq progseq_chk #(.LO_W(LO_W), .PAGE_W(PAGE_W), .VEC(VEC)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .op          (op),
  .irq_take    (irq_take),
  .reti_take   (reti_take),
  .page_commit (page_commit),
  .irq         (irq),
  .prog_addr   (prog_addr),
  .in_isr      (in_isr),
  .restore_vld (restore_vld)
);

// File: tb/progseq_tb.sv
`timescale 1ns/1ps
module progseq_tb;

  localparam int LO_W = 10;
  localparam int PW   = 4;
  localparam int DW   = 8;
  localparam int VEC  = 8;
  localparam int AW   = PW + LO_W;

  logic clk = 1'b0;
  logic rst, step, jump, call, pc_add, pc_mov, irq, reti;
  logic [LO_W-1:0] target;
  logic [DW-1:0] operand, acc_in, stat_in, pagereg_in;
  logic [AW-1:0] prog_addr;
  logic in_isr, restore_vld;
  logic [DW-1:0] restore_acc, restore_stat, restore_pagereg;

  always #2 clk = ~clk;

  progseq u_dut (
    .clk(clk), .rst(rst), .step(step), .jump(jump), .call(call),
    .pc_add(pc_add), .pc_mov(pc_mov), .irq(irq), .reti(reti),
    .target(target), .operand(operand), .acc_in(acc_in), .stat_in(stat_in),
    .pagereg_in(pagereg_in), .prog_addr(prog_addr), .in_isr(in_isr),
    .restore_vld(restore_vld), .restore_acc(restore_acc),
    .restore_stat(restore_stat), .restore_pagereg(restore_pagereg)
  );

  int n_chk  = 0;
  int n_fail = 0;
  bit done   = 1'b0;

  // model state
  logic [LO_W-1:0] m_lo, m_rlo;
  logic [PW-1:0]   m_pg, m_rpg;
  logic            m_v, m_rv;
  logic [DW-1:0]   m_acc, m_stat, m_page;
  string           m_tag;

  function automatic logic [LO_W-1:0] exp_add(input logic [LO_W-1:0] a, input logic [DW-1:0] b);
    int s;
    s = (int'(a) + int'(b)) % (1 << LO_W);
    return s[LO_W-1:0];
  endfunction

  function automatic logic [LO_W-1:0] exp_mov(input logic [LO_W-1:0] a, input logic [DW-1:0] b);
    logic [LO_W-1:0] r;
    r = a;
    r[DW-1:0] = b;
    return r;
  endfunction

  task automatic chk(input string tag, input string what, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: got %0h expected %0h", tag, what, got, exp);
    end
  endtask

  task automatic model_reset();
    m_lo = '0; m_pg = '0; m_v = 1'b0; m_rv = 1'b0; m_tag = "R1";
  endtask

  // advance the model with the inputs just driven
  task automatic model_step();
    if (rst) begin
      model_reset();
    end else if (irq && !m_v) begin
      m_rlo = m_lo + 1'b1; m_rpg = m_pg;
      m_acc = acc_in; m_stat = stat_in; m_page = pagereg_in;
      m_lo = LO_W'(VEC); m_pg = '0; m_v = 1'b1; m_rv = 1'b0;
      m_tag = (jump || step || reti) ? "R7/R8" : "R7";
    end else begin
      string sfx;
      sfx = (irq || reti) ? (irq ? "/R8" : "/R10") : "";
      if (reti && m_v) begin
        m_lo = m_rlo; m_pg = m_rpg; m_v = 1'b0; m_rv = 1'b1; m_tag = "R9";
      end else begin
        m_rv = 1'b0;
        if (jump) begin
          m_lo = target; m_pg = pagereg_in[PW-1:0];
          m_tag = (call || pc_add || pc_mov || step) ? "R3/R11" : "R3";
        end else if (call) begin
          m_lo = target; m_pg = pagereg_in[PW-1:0];
          m_tag = (pc_add || pc_mov || step) ? "R3/R11" : "R3";
        end else if (pc_add) begin
          m_lo = exp_add(m_lo, operand); m_pg = pagereg_in[PW-1:0];
          m_tag = (pc_mov || step) ? "R4/R11" : "R4";
        end else if (pc_mov) begin
          m_lo = exp_mov(m_lo, operand); m_pg = pagereg_in[PW-1:0];
          m_tag = step ? "R5/R11" : "R5";
        end else if (step) begin
          m_lo = m_lo + 1'b1; m_tag = "R2/R6";
        end else begin
          m_tag = "R6";
        end
        m_tag = {m_tag, sfx};
      end
    end
  endtask

  task automatic check_outputs();
    chk(m_tag, "prog_addr", 32'(prog_addr), 32'({m_pg, m_lo}));
    chk(m_tag, "in_isr", 32'(in_isr), 32'(m_v));
    chk(m_tag, "restore_vld", 32'(restore_vld), 32'(m_rv));
    if (m_rv) begin
      chk("R9", "restore_acc", 32'(restore_acc), 32'(m_acc));
      chk("R9", "restore_stat", 32'(restore_stat), 32'(m_stat));
      chk("R9", "restore_pagereg", 32'(restore_pagereg), 32'(m_page));
    end
  endtask

  task automatic idle_inputs();
    step = 0; jump = 0; call = 0; pc_add = 0; pc_mov = 0; irq = 0; reti = 0;
  endtask

  // one cycle: drive on falling edge, check on the following falling edge
  task automatic cycle();
    model_step();
    @(negedge clk);
    check_outputs();
  endtask

  initial begin
    #(4 * 60000);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: got hang expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    idle_inputs();
    rst = 1; target = '0; operand = '0; acc_in = '0; stat_in = '0; pagereg_in = '0;
    model_reset();
    @(negedge clk);
    cycle();
    rst = 0;

    // R2 wrap within page: jump to top of page 5, then step
    jump = 1; target = '1; pagereg_in = 8'h35; cycle();
    idle_inputs(); step = 1; pagereg_in = 8'h3A; cycle();
    // R6 page field changes with no strobe
    idle_inputs(); pagereg_in = 8'h0C; cycle();
    // R5 byte replace keeps upper bits
    target = 10'h2F0; jump = 1; pagereg_in = 8'h02; cycle();
    idle_inputs(); pc_mov = 1; operand = 8'h11; pagereg_in = 8'h07; cycle();
    // R4 add with wrap
    idle_inputs(); pc_add = 1; operand = 8'hFF; cycle();
    idle_inputs(); jump = 1; target = 10'h3F0; cycle();
    idle_inputs(); pc_add = 1; operand = 8'h20; cycle();
    // R10 return with empty shadow
    idle_inputs(); reti = 1; step = 1; cycle();
    // R7 interrupt beats a jump; R8 second request masked
    idle_inputs(); irq = 1; jump = 1; acc_in = 8'hA5; stat_in = 8'h5A; pagereg_in = 8'h09; cycle();
    idle_inputs(); irq = 1; step = 1; acc_in = 8'h00; cycle();
    idle_inputs(); call = 1; pc_add = 1; target = 10'h155; pagereg_in = 8'h0B; cycle();
    // R9 return restores
    idle_inputs(); reti = 1; cycle();
    idle_inputs(); cycle();

    // constrained random phase
    for (int i = 0; i < 4000; i++) begin
      int r;
      idle_inputs();
      r = int'($urandom % 100);
      step   = (r < 55);
      jump   = ($urandom % 12) == 0;
      call   = ($urandom % 14) == 0;
      pc_add = ($urandom % 10) == 0;
      pc_mov = ($urandom % 12) == 0;
      irq    = ($urandom % 15) == 0;
      reti   = ($urandom % 9) == 0;
      rst    = ($urandom % 500) == 0;
      target     = LO_W'($urandom);
      operand    = DW'($urandom);
      acc_in     = DW'($urandom);
      stat_in    = DW'($urandom);
      pagereg_in = DW'($urandom);
      cycle();
    end

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule